// File: doc/BRIEF.md
# Packed Lane Compare, Select and Arithmetic Unit

The block takes two 64-bit operands and treats each one as a row of lanes that are 8, 16 or 32 bits wide. The same operation runs on every lane pair. It can test for equality or ordering, pick the smaller or the larger lane, add or subtract with wrap-around, or take the mean of the two lanes with or without rounding. Next to the 64-bit result it writes a 32-bit status word. That word holds a negative flag and a zero flag for each lane, and the positions of those flags depend on the lane width.

A request is presented with `in_valid` high for one clock. The operands, operation and lane size are evaluated in that cycle. Result and status are captured together and appear with `out_valid` on the next cycle. They hold their value until the next request arrives. The unit has no back-pressure, and a new request may be issued every cycle.

Top module: `lane_cmp_unit`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `result` and `status` change only in the cycle after `in_valid` is high, and otherwise keep their last value.
- R2: While `rst_n` is low, `out_valid`, `result` and `status` are all zero.
- R3: The compare codes are equal (`op`=0), signed greater (`op`=1) and unsigned greater (`op`=2). Each one fills a lane with all ones when lane A relates to lane B that way, and with all zeros otherwise.
- R4: The selection codes are signed min (`op`=3), unsigned min (`op`=4), signed max (`op`=5) and unsigned max (`op`=6). Each one copies the winning lane unchanged, and on a tie the B lane is taken.
- R5: Add (`op`=7) and subtract A minus B (`op`=8) keep only the low lane-width bits of every lane sum or difference.
- R6: Average (`op`=9) gives (A + B + `rnd`) >> 1 per lane, computed without losing the carry. For average, every negative flag reads zero.
- R7: With byte lanes (`lane_sz`=0), lane i puts its negative flag at status bit 4i+3 and its zero flag at bit 4i+2.
- R8: With halfword lanes (`lane_sz`=1), the negative flag of lane h is at bit 8h+7 and its zero flag at bit 8h+6. With word lanes (`lane_sz`=2, or 3, which is treated the same), the negative flag of lane w is at bit 16w+15 and its zero flag at bit 16w+14.
- R9: A lane's negative flag equals the top bit of its result. Its zero flag is set exactly when the lane result is all zero.
- R10: Every status bit that the current lane size does not assign is zero.
- R11: Operation codes 10 to 15 produce a zero result and a zero status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation code |
| lane_sz | input | 2 | Lane width: 0 byte, 1 halfword, 2 or 3 word |
| rnd | input | 1 | Rounding bit for average |
| src_a | input | 64 | Operand A |
| src_b | input | 64 | Operand B |
| out_valid | output | 1 | Result strobe |
| result | output | 64 | Packed lane result |
| status | output | 32 | Per-lane negative and zero flags |

## Verification
The hardest cases to reach are the ones where wrap-around and sign interpretation meet at a lane boundary. These include a signed compare where one lane holds the most negative value and the other the most positive, an add whose carry must not spill into the next lane, and an average whose intermediate sum needs one bit more than the lane. The vector table builds each of these cases on purpose. The operands put 0x80/0x7F, 0x8000/0x7FFF and all-ones patterns in neighbouring lanes, so a leaked carry or a flipped sign test changes a lane that would otherwise be zero, and with it the zero flag.

// File: rtl/lcu_pkg.sv
package lcu_pkg;

    localparam int DATA_W = 64;
    localparam int STAT_W = DATA_W / 2;
    localparam int OP_W   = 4;
    localparam int SZ_W   = 2;
    localparam int N_SIZES = 3;

    typedef enum logic [OP_W-1:0] {
        OP_EQ   = 4'd0,
        OP_GTS  = 4'd1,
        OP_GTU  = 4'd2,
        OP_MINS = 4'd3,
        OP_MINU = 4'd4,
        OP_MAXS = 4'd5,
        OP_MAXU = 4'd6,
        OP_ADD  = 4'd7,
        OP_SUB  = 4'd8,
        OP_AVG  = 4'd9
    } lcu_op_e;

    localparam logic [SZ_W-1:0] SZ_BYTE = 2'd0;
    localparam logic [SZ_W-1:0] SZ_HALF = 2'd1;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
        logic [STAT_W-1:0] st;
    } lcu_state_t;

    function automatic logic op_known(input logic [OP_W-1:0] code);
        return code <= OP_AVG;
    endfunction

endpackage

// File: rtl/lcu_lane.sv
module lcu_lane
    import lcu_pkg::*;
#(
    parameter int LW = 8
) (
    input  logic [OP_W-1:0] op,
    input  logic            rnd,
    input  logic [LW-1:0]   a,
    input  logic [LW-1:0]   b,
    output logic [LW-1:0]   res,
    output logic            neg,
    output logic            zero
);

    logic          gt_s;
    logic          gt_u;
    logic          lt_s;
    logic          lt_u;
    logic [LW:0]   mean_sum;

    always_comb begin
        gt_s     = $signed(a) > $signed(b);
        lt_s     = $signed(a) < $signed(b);
        gt_u     = a > b;
        lt_u     = a < b;
        mean_sum = {1'b0, a} + {1'b0, b} + {{LW{1'b0}}, rnd};

        case (op)
            OP_EQ:   res = (a == b) ? '1 : '0;
            OP_GTS:  res = gt_s ? '1 : '0;
            OP_GTU:  res = gt_u ? '1 : '0;
            OP_MINS: res = lt_s ? a : b;
            OP_MINU: res = lt_u ? a : b;
            OP_MAXS: res = gt_s ? a : b;
            OP_MAXU: res = gt_u ? a : b;
            OP_ADD:  res = a + b;
            OP_SUB:  res = a - b;
            OP_AVG:  res = mean_sum[LW:1];
            default: res = '0;
        endcase

        neg  = res[LW-1] & (op != OP_AVG);
        zero = (res == '0);
    end

endmodule

// File: rtl/lcu_flag_pack.sv
module lcu_flag_pack
    import lcu_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic [LANES-1:0]  neg_vec,
    input  logic [LANES-1:0]  zero_vec,
    output logic [STAT_W-1:0] status
);

    localparam int STRIDE = STAT_W / LANES;

    always_comb begin
        status = '0;
        for (int i = 0; i < LANES; i++) begin
            status[i*STRIDE + STRIDE - 1] = neg_vec[i];
            status[i*STRIDE + STRIDE - 2] = zero_vec[i];
        end
    end

endmodule

// File: rtl/lane_cmp_unit.sv
module lane_cmp_unit
    import lcu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op,
    input  logic [SZ_W-1:0]   lane_sz,
    input  logic              rnd,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic [STAT_W-1:0] status
);

    logic [DATA_W-1:0] bank_res [N_SIZES];
    logic [STAT_W-1:0] bank_st  [N_SIZES];

    for (genvar gs = 0; gs < N_SIZES; gs++) begin : g_size
        localparam int LW = 8 << gs;
        localparam int NL = DATA_W / LW;

        logic [DATA_W-1:0] lane_res;
        logic [NL-1:0]     lane_neg;
        logic [NL-1:0]     lane_zero;
        logic [STAT_W-1:0] lane_st;

        for (genvar gl = 0; gl < NL; gl++) begin : g_lane
            lcu_lane #(.LW(LW)) u_lane (
                .op   (op),
                .rnd  (rnd),
                .a    (src_a[gl*LW +: LW]),
                .b    (src_b[gl*LW +: LW]),
                .res  (lane_res[gl*LW +: LW]),
                .neg  (lane_neg[gl]),
                .zero (lane_zero[gl])
            );
        end

        lcu_flag_pack #(.LANES(NL)) u_pack (
            .neg_vec  (lane_neg),
            .zero_vec (lane_zero),
            .status   (lane_st)
        );

        assign bank_res[gs] = lane_res;
        assign bank_st[gs]  = lane_st;
    end

    lcu_state_t state_d;
    lcu_state_t state_q;

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            if (!op_known(op)) begin
                state_d.res = '0;
                state_d.st  = '0;
            end else if (lane_sz == SZ_BYTE) begin
                state_d.res = bank_res[0];
                state_d.st  = bank_st[0];
            end else if (lane_sz == SZ_HALF) begin
                state_d.res = bank_res[1];
                state_d.st  = bank_st[1];
            end else begin
                state_d.res = bank_res[2];
                state_d.st  = bank_st[2];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign result    = state_q.res;
    assign status    = state_q.st;

endmodule

// File: rtl/lcu_checker.sv
module lcu_checker
    import lcu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [OP_W-1:0]   op,
    input logic [SZ_W-1:0]   lane_sz,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic [STAT_W-1:0] status
);

    assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> out_valid == $past(in_valid));

    assert_hold_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result) && $stable(status));

    assert_eq_self_all_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op == OP_EQ && src_a == src_b |=> result == '1);

    for (genvar gb = 0; gb < DATA_W/8; gb++) begin : g_byte_chk
        assert_cmp_lane_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && op <= OP_GTU && lane_sz == SZ_BYTE
            |=> result[gb*8 +: 8] == 8'h00 || result[gb*8 +: 8] == 8'hFF);
    end

    assert_avg_no_neg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op == OP_AVG |=> (status & 32'h8888_8888) == '0);

    assert_byte_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && lane_sz == SZ_BYTE |=> (status & 32'h3333_3333) == '0);

    assert_half_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && lane_sz == SZ_HALF |=> (status & 32'h3F3F_3F3F) == '0);

    assert_word_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && lane_sz[1] |=> (status & 32'h3FFF_3FFF) == '0);

    assert_unknown_op_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op > OP_AVG |=> result == '0 && status == '0);

endmodule

bind lane_cmp_unit lcu_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .lane_sz   (lane_sz),
    .src_a     (src_a),
    .src_b     (src_b),
    .out_valid (out_valid),
    .result    (result),
    .status    (status)
);

// File: tb/sim_lane_cmp_unit.sv
module sim_lane_cmp_unit;

    localparam int CLK_PERIOD = 10;
    localparam int N_VEC = 14;

    typedef struct packed {
        logic [3:0]  op;
        logic [1:0]  sz;
        logic        rnd;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] r;
        logic [31:0] s;
    } vec_t;

    localparam vec_t VECS [N_VEC] = '{
        // R3 equality, byte lanes
        '{4'd0, 2'd0, 1'b0, 64'h00FF_1234_5678_0000, 64'h00FF_1200_5678_0001, 64'hFFFF_FF00_FFFF_FF00, 32'h8884_8884},
        // R3 signed greater, halfword
        '{4'd1, 2'd1, 1'b0, 64'h8000_7FFF_0001_FFFF, 64'h7FFF_8000_0001_0000, 64'h0000_FFFF_0000_0000, 32'h4080_4040},
        // R3 unsigned greater, halfword
        '{4'd2, 2'd1, 1'b0, 64'h8000_7FFF_0001_FFFF, 64'h7FFF_8000_0001_0000, 64'hFFFF_0000_0000_FFFF, 32'h8040_4080},
        // R4 signed min, byte
        '{4'd3, 2'd0, 1'b0, 64'h807F_0505_FF01_0010, 64'h7F80_0506_01FF_1000, 64'h8080_0505_FFFF_0000, 32'h8800_8844},
        // R4 unsigned max, byte
        '{4'd6, 2'd0, 1'b0, 64'h807F_0505_FF01_0010, 64'h7F80_0506_01FF_1000, 64'h8080_0506_FFFF_1010, 32'h8800_8800},
        // R5 wrapping add, word
        '{4'd7, 2'd2, 1'b0, 64'hFFFF_FFFF_0000_0001, 64'h0000_0001_7FFF_FFFF, 64'h0000_0000_8000_0000, 32'h4000_8000},
        // R5 wrapping subtract, byte
        '{4'd8, 2'd0, 1'b0, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_00FF, 32'h4444_4448},
        // R6 rounded average, byte
        '{4'd9, 2'd0, 1'b1, 64'h0000_0000_0000_FF01, 64'h0000_0000_0000_FF00, 64'h0000_0000_0000_FF01, 32'h4444_4400},
        // R6 truncated average, byte
        '{4'd9, 2'd0, 1'b0, 64'h0000_0000_0000_FF01, 64'h0000_0000_0000_FF00, 64'h0000_0000_0000_FF00, 32'h4444_4404},
        // R6 rounded average, halfword
        '{4'd9, 2'd1, 1'b1, 64'h0000_0000_0003_FFFF, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0002_FFFF, 32'h4040_0000},
        // R11 unknown op
        '{4'd15, 2'd0, 1'b0, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0002, 64'h0, 32'h0},
        // R8 lane size 3 acts as word
        '{4'd0, 2'd3, 1'b0, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 32'h8000_8000},
        // R4 signed min, word
        '{4'd3, 2'd2, 1'b0, 64'h8000_0000_0000_0005, 64'h7FFF_FFFF_0000_0007, 64'h8000_0000_0000_0005, 32'h8000_0000},
        // R4 unsigned min, word
        '{4'd4, 2'd2, 1'b0, 64'h8000_0000_0000_0005, 64'h7FFF_FFFF_0000_0007, 64'h7FFF_FFFF_0000_0005, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [1:0]  lane_sz = '0;
    logic        rnd = 1'b0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        out_valid;
    logic [63:0] result;
    logic [31:0] status;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_cmp_unit u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op        (op),
        .lane_sz   (lane_sz),
        .rnd       (rnd),
        .src_a     (src_a),
        .src_b     (src_b),
        .out_valid (out_valid),
        .result    (result),
        .status    (status)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string res_tag(input logic [3:0] code);
        if (code <= 4'd2) return "R3";
        if (code <= 4'd6) return "R4";
        if (code <= 4'd8) return "R5";
        if (code == 4'd9) return "R6";
        return "R11";
    endfunction

    task automatic issue(input vec_t v);
        @(negedge clk);
        in_valid = 1'b1;
        op       = v.op;
        lane_sz  = v.sz;
        rnd      = v.rnd;
        src_a    = v.a;
        src_b    = v.b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R2 reset state
        repeat (3) @(negedge clk);
        check("R2 out_valid", {63'd0, out_valid}, 64'd0);
        check("R2 result", result, 64'd0);
        check("R2 status", {32'd0, status}, 64'd0);
        rst_n = 1'b1;

        // table walk
        for (int i = 0; i < N_VEC; i++) begin
            issue(VECS[i]);
            check("R1 out_valid", {63'd0, out_valid}, 64'd1);
            check(res_tag(VECS[i].op), result, VECS[i].r);
            check(VECS[i].sz == 2'd0 ? "R7 R9 R10 status" : "R8 R9 R10 status",
                  {32'd0, status}, {32'd0, VECS[i].s});
        end

        // R1: idle inputs change, outputs hold, out_valid low
        @(negedge clk);
        op = 4'd7; src_a = 64'h1111_1111_1111_1111; src_b = 64'h2222_2222_2222_2222;
        @(negedge clk);
        check("R1 idle out_valid", {63'd0, out_valid}, 64'd0);
        check("R1 idle result hold", result, VECS[N_VEC-1].r);
        check("R1 idle status hold", {32'd0, status}, {32'd0, VECS[N_VEC-1].s});

        // R1: back-to-back requests
        @(negedge clk);
        in_valid = 1'b1; op = 4'd7; lane_sz = 2'd0;
        src_a = 64'h0102_0304_0506_0708; src_b = 64'h0101_0101_0101_0101;
        @(negedge clk);
        check("R1 b2b first", result, 64'h0203_0405_0607_0809);
        op = 4'd8;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 b2b second", result, 64'h0001_0203_0405_0607);
        check("R7 b2b status", {32'd0, status}, 64'h0000_0000_4000_0000);

        // R2 reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R2 mid reset result", result, 64'd0);
        check("R2 mid reset status", {32'd0, status}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule